// File: doc/BRIEF.md
# I2C Status Flag Register Pair with Sequence-Cleared Events

This block holds the status state of an I2C controller: two status words, the
interrupt enables, and the interrupt requests they gate. The protocol engine
raises flags through one-cycle set strobes. Software sees the flags through a
small register bus that has an address, read and write strobes, and 16-bit write
data. The engine mirrors eight live status bits into the second status word.

Protocol event flags have no direct write path. A small state machine arms when
status word 1 is read. The next bus access then clears the flags that match that
access, and any other access disarms it. Buffer flags clear on the matching data
access alone. Error flags clear when software writes a zero to their bit. The
two status words are also presented together as one 24-bit event word.

State machine states and transitions:
- SEQ_IDLE goes to SEQ_ARMED on a status-1 read.
- SEQ_ARMED stays in SEQ_ARMED on another status-1 read or on a cycle with no access.
- SEQ_ARMED goes to SEQ_IDLE on any other access. This includes the completing access, which clears its flags as it leaves.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset, status word 1, status word 2, the event word, the interrupt enables and all three interrupt requests are zero, and the sequencer is disarmed.
- R2: A set strobe on a bit of `set_st1` makes that status-1 bit one on the next clock. Bits 5 and 13 are not implemented and always read zero.
- R3: Start-sent (bit 0) and 10-bit-header-sent (bit 3) clear only when a status-1 read (address 5) is followed by a data write (address 4).
- R4: Address-done (bit 1) clears only when a status-1 read is followed by a status-2 read (address 6).
- R5: Byte-complete (bit 2) clears when a status-1 read is followed by a data read or a data write.
- R6: Stop-seen (bit 4) clears when a status-1 read is followed by a control-1 write (address 0). Idle cycles between the two accesses keep the sequencer armed.
- R7: Any access other than a status-1 read ends the armed state, so a completing access clears nothing unless it comes right after a status-1 read with no other access between.
- R8: Error bits 8–12, 14 and 15 clear when status word 1 (address 5) is written with a zero in that bit. A one leaves the bit unchanged. Writes to status word 1 never change bits 0–7.
- R9: Receive-full (bit 6) clears on any data read, and transmit-empty (bit 7) clears on any data write, whether or not the sequencer is armed.
- R10: When a set strobe and a clear condition hit the same bit in the same cycle, the bit ends up one.
- R11: Status word 2 shows `eng_st2` one clock later in bits 7:0, with zeros above. The event word is status word 2 bits 7:0 in bits 23:16 above status word 1 in bits 15:0.
- R12: A write to control-2 (address 1) stores the enables: bit 8 for error, bit 9 for event, bit 10 for buffer. Each interrupt request is high exactly when its enable is set and a flag in its group is set. The groups are error (bits 8–15), event (bits 0–4) and buffer (bits 6–7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| set_st1 | input | 16 | Per-bit set strobes from the protocol engine |
| eng_st2 | input | 8 | Live status bits from the protocol engine |
| st1 | output | 16 | Status word 1 |
| st2 | output | 16 | Status word 2 |
| evt_word | output | 24 | Combined event word |
| irq_evt | output | 1 | Event interrupt request |
| irq_buf | output | 1 | Buffer interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Every bus access, set strobe and `eng_st2` value takes effect in the flag, enable and status-2 registers at the next rising edge. The event word and the interrupt requests are decoded from those registers without further delay, so all results are due one clock after the stimulus. The bench drives each stimulus on a falling edge and advances its own model by one step. It then compares every output at the following falling edge, half a period after the results become valid. Directed sequences cover arming, disarming, idle gaps, and same-cycle set and clear. Seeded random traffic then mixes all of these together.

// File: rtl/isf_pkg.sv
package isf_pkg;
    localparam int DW  = 16;
    localparam int AW  = 3;
    localparam int S2W = 8;
    localparam int EW  = DW + S2W;

    localparam logic [AW-1:0] A_CTL1 = 3'd0;
    localparam logic [AW-1:0] A_CTL2 = 3'd1;
    localparam logic [AW-1:0] A_DATA = 3'd4;
    localparam logic [AW-1:0] A_ST1  = 3'd5;
    localparam logic [AW-1:0] A_ST2  = 3'd6;

    localparam int B_START = 0;
    localparam int B_ADDR  = 1;
    localparam int B_BYTE  = 2;
    localparam int B_HDR10 = 3;
    localparam int B_STOP  = 4;
    localparam int B_RXF   = 6;
    localparam int B_TXE   = 7;

    localparam int EN_ERR = 8;
    localparam int EN_EVT = 9;
    localparam int EN_BUF = 10;

    localparam logic [DW-1:0] EVT_MASK  = 16'h001F;
    localparam logic [DW-1:0] BUF_MASK  = 16'h00C0;
    localparam logic [DW-1:0] ERR_MASK  = 16'hDF00;
    localparam logic [DW-1:0] LIVE_MASK = EVT_MASK | BUF_MASK | ERR_MASK;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic buf_en;
        logic evt_en;
        logic err_en;
    } irq_en_t;
endpackage

// File: rtl/isf_seq_fsm.sv
module isf_seq_fsm
    import isf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st1_rd,
    input  logic          bus_act,
    input  logic          data_rd,
    input  logic          data_wr,
    input  logic          st2_rd,
    input  logic          ctl1_wr,
    output logic [DW-1:0] seq_clr,
    output logic          armed
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (st1_rd) state_nx = SEQ_ARMED;
            SEQ_ARMED: begin
                if (st1_rd)       state_nx = SEQ_ARMED;
                else if (bus_act) state_nx = SEQ_IDLE;
            end
        endcase
    end

    always_comb begin
        seq_clr = '0;
        armed   = 1'b0;
        unique case (state)
            SEQ_IDLE: ;
            SEQ_ARMED: begin
                armed = 1'b1;
                if (data_wr) begin
                    seq_clr[B_START] = 1'b1;
                    seq_clr[B_HDR10] = 1'b1;
                    seq_clr[B_BYTE]  = 1'b1;
                end
                if (data_rd) seq_clr[B_BYTE] = 1'b1;
                if (st2_rd)  seq_clr[B_ADDR] = 1'b1;
                if (ctl1_wr) seq_clr[B_STOP] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/isf_flag_bank.sv
module isf_flag_bank #(
    parameter int          W    = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic unused_bits;
    assign unused_bits = ^(set & clr & ~MASK);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[i] <= 1'b0;
                else        q[i] <= set[i] | (q[i] & ~clr[i]);
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isf_irq_gate.sv
module isf_irq_gate
    import isf_pkg::*;
(
    input  logic [DW-1:0] flags,
    input  irq_en_t       en,
    output logic          irq_evt,
    output logic          irq_buf,
    output logic          irq_err
);
    always_comb begin
        irq_evt = en.evt_en & (|(flags & EVT_MASK));
        irq_buf = en.buf_en & (|(flags & BUF_MASK));
        irq_err = en.err_en & (|(flags & ERR_MASK));
    end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import isf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] set_st1,
    input  logic [S2W-1:0] eng_st2,
    output logic [DW-1:0] st1,
    output logic [DW-1:0] st2,
    output logic [EW-1:0] evt_word,
    output logic          irq_evt,
    output logic          irq_buf,
    output logic          irq_err
);
    logic           st1_rd, st1_wr, data_rd, data_wr, st2_rd, ctl1_wr, ctl2_wr, bus_act;
    logic [DW-1:0]  seq_clr, err_clr, buf_clr, all_clr;
    logic           seq_armed;
    irq_en_t        en_q;
    logic [S2W-1:0] st2_q;
    logic           unused_wd;

    assign unused_wd = ^bus_wdata[7:0];

    always_comb begin
        bus_act = bus_rd | bus_wr;
        st1_rd  = bus_rd & (bus_addr == A_ST1);
        st1_wr  = bus_wr & (bus_addr == A_ST1);
        data_rd = bus_rd & (bus_addr == A_DATA);
        data_wr = bus_wr & (bus_addr == A_DATA);
        st2_rd  = bus_rd & (bus_addr == A_ST2);
        ctl1_wr = bus_wr & (bus_addr == A_CTL1);
        ctl2_wr = bus_wr & (bus_addr == A_CTL2);
    end

    isf_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .st1_rd  (st1_rd),
        .bus_act (bus_act),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .st2_rd  (st2_rd),
        .ctl1_wr (ctl1_wr),
        .seq_clr (seq_clr),
        .armed   (seq_armed)
    );

    always_comb begin
        err_clr = st1_wr ? (~bus_wdata & ERR_MASK) : '0;
        buf_clr = '0;
        buf_clr[B_RXF] = data_rd;
        buf_clr[B_TXE] = data_wr;
        all_clr = seq_clr | err_clr | buf_clr;
    end

    isf_flag_bank #(.W(DW), .MASK(LIVE_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_st1),
        .clr   (all_clr),
        .q     (st1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            st2_q <= '0;
        end else begin
            st2_q <= eng_st2;
            if (ctl2_wr) begin
                en_q.err_en <= bus_wdata[EN_ERR];
                en_q.evt_en <= bus_wdata[EN_EVT];
                en_q.buf_en <= bus_wdata[EN_BUF];
            end
        end
    end

    assign st2      = {{(DW-S2W){1'b0}}, st2_q};
    assign evt_word = {st2_q, st1};

    isf_irq_gate u_irq (
        .flags   (st1),
        .en      (en_q),
        .irq_evt (irq_evt),
        .irq_buf (irq_buf),
        .irq_err (irq_err)
    );
endmodule

// File: rtl/isf_checker.sv
module isf_checker
    import isf_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          wd_b8,
    input logic          set_start,
    input logic          set_addr,
    input logic          st1_start,
    input logic          st1_addr,
    input logic          st1_b8,
    input logic [DW-1:0] st2,
    input logic [S2W-1:0] eng_st2,
    input logic          irq_err,
    input logic          seq_armed
);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_start |=> st1_start);

    a_r7_idle_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_armed && st1_start) |=> st1_start);

    a_r4_addr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_armed && bus_rd && bus_addr == A_ST2 && !set_addr) |=> !st1_addr);

    a_r8_one_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ST1 && wd_b8 && st1_b8) |=> st1_b8);

    a_r11_st2_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st2 == {{(DW-S2W){1'b0}}, $past(eng_st2)}));

    a_r12_err_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL2 && !wd_b8) |=> !irq_err);
endmodule

bind i2c_status_flags isf_checker u_isf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .wd_b8     (bus_wdata[8]),
    .set_start (set_st1[0]),
    .set_addr  (set_st1[1]),
    .st1_start (st1[0]),
    .st1_addr  (st1[1]),
    .st1_b8    (st1[8]),
    .st2       (st2),
    .eng_st2   (eng_st2),
    .irq_err   (irq_err),
    .seq_armed (seq_armed)
);

// File: tb/i2c_status_flags_test.sv
`timescale 1ns/1ps
module i2c_status_flags_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [15:0] bus_wdata, set_st1;
    logic [7:0]  eng_st2;
    logic [15:0] st1, st2;
    logic [23:0] evt_word;
    logic        irq_evt, irq_buf, irq_err;

    always #2 clk = ~clk;

    i2c_status_flags uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .set_st1(set_st1),
        .eng_st2(eng_st2), .st1(st1), .st2(st2), .evt_word(evt_word),
        .irq_evt(irq_evt), .irq_buf(irq_buf), .irq_err(irq_err)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m1;
    logic [7:0]  m2;
    logic [2:0]  men;
    bit          marm;

    function automatic logic [15:0] nxt_st1(input logic [15:0] cur, input bit arm,
            input logic [15:0] set, input logic rd, input logic wr,
            input logic [2:0] a, input logic [15:0] wd);
        logic [15:0] c = 16'h0;
        if (arm) begin
            if (wr && a == 3'd4) c |= 16'h000D;
            if (rd && a == 3'd4) c |= 16'h0004;
            if (rd && a == 3'd6) c |= 16'h0002;
            if (wr && a == 3'd0) c |= 16'h0010;
        end
        if (rd && a == 3'd4) c |= 16'h0040;
        if (wr && a == 3'd4) c |= 16'h0080;
        if (wr && a == 3'd5) c |= (~wd & 16'hDF00);
        return ((cur & ~c) | set) & 16'hDFDF;
    endfunction

    function automatic bit nxt_arm(input bit arm, input logic rd, input logic wr,
            input logic [2:0] a);
        if (rd && a == 3'd5) return 1'b1;
        if (rd || wr)        return 1'b0;
        return arm;
    endfunction

    function automatic logic [2:0] exp_irq(input logic [15:0] f, input logic [2:0] en);
        return {en[1] & |(f & 16'h001F), en[2] & |(f & 16'h00C0), en[0] & |(f & 16'hDF00)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic rd, input logic wr,
            input logic [2:0] a, input logic [15:0] wd, input logic [15:0] set);
        logic [15:0] n1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; set_st1 = set;
        n1   = nxt_st1(m1, marm, set, rd, wr, a, wd);
        marm = nxt_arm(marm, rd, wr, a);
        if (wr && a == 3'd1) men = wd[10:8];
        m2 = eng_st2;
        m1 = n1;
        @(negedge clk);
        chk(req, {16'h0, st1}, {16'h0, m1});
        chk(req, {16'h0, st2}, {24'h0, m2});
        chk(req, {8'h0, evt_word}, {8'h0, m2, m1});
        chk(req, {29'h0, irq_evt, irq_buf, irq_err}, {29'h0, exp_irq(m1, men)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] ra;
        int r;
        rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0;
        bus_wdata = '0; set_st1 = '0; eng_st2 = '0;
        m1 = '0; m2 = '0; men = '0; marm = 1'b0;
        r = $urandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {16'h0, st1}, 32'h0);
        chk("R1", {16'h0, st2}, 32'h0);
        chk("R1", {8'h0, evt_word}, 32'h0);
        chk("R1", {29'h0, irq_evt, irq_buf, irq_err}, 32'h0);

        step("R2", 0, 0, 3'd0, 16'h0, 16'h0001);
        step("R2", 0, 0, 3'd0, 16'h0, 16'h2020);
        step("R7", 0, 1, 3'd4, 16'h0055, 16'h0);    // unarmed data write
        step("R3", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R3", 0, 1, 3'd4, 16'h0, 16'h0);       // start cleared
        step("R4", 0, 0, 3'd0, 16'h0, 16'h0002);
        step("R7", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R7", 0, 1, 3'd1, 16'h0700, 16'h0);    // disarm, enables on
        step("R7", 1, 0, 3'd6, 16'h0, 16'h0);       // addr flag stays
        step("R4", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R4", 1, 0, 3'd6, 16'h0, 16'h0);       // addr flag cleared
        step("R5", 0, 0, 3'd0, 16'h0, 16'h0044);
        step("R5", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R5", 1, 0, 3'd4, 16'h0, 16'h0);
        step("R6", 0, 0, 3'd0, 16'h0, 16'h0010);
        step("R6", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R6", 0, 0, 3'd0, 16'h0, 16'h0);       // idle keeps arm
        step("R6", 0, 1, 3'd0, 16'h0, 16'h0);
        step("R3", 0, 0, 3'd0, 16'h0, 16'h0009);
        step("R3", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R3", 0, 1, 3'd4, 16'h0, 16'h0);
        step("R8", 0, 0, 3'd0, 16'h0, 16'hFF00);
        step("R8", 0, 1, 3'd5, 16'hFEFF, 16'h0);
        step("R8", 0, 0, 3'd0, 16'h0, 16'h0001);
        step("R8", 0, 1, 3'd5, 16'h0000, 16'h0);
        step("R10", 1, 0, 3'd5, 16'h0, 16'h0);
        step("R10", 0, 1, 3'd4, 16'h0, 16'h0001);
        step("R9", 0, 0, 3'd0, 16'h0, 16'h00C0);
        step("R9", 0, 1, 3'd4, 16'h0, 16'h0);
        step("R9", 1, 0, 3'd4, 16'h0, 16'h0);
        step("R12", 0, 0, 3'd0, 16'h0, 16'h0140);
        step("R12", 0, 1, 3'd1, 16'h0200, 16'h0);
        eng_st2 = 8'hA5;
        step("R11", 0, 0, 3'd0, 16'h0, 16'h0);
        eng_st2 = 8'h3C;
        step("R11", 0, 0, 3'd2, 16'h0, 16'h0);

        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 6)
                0: ra = 3'd0;
                1: ra = 3'd1;
                2: ra = 3'd2;
                3: ra = 3'd4;
                4: ra = 3'd5;
                default: ra = 3'd6;
            endcase
            r = $urandom % 4;
            eng_st2 = 8'($urandom);
            step("R7", r == 1, r == 2, ra, 16'($urandom),
                 16'($urandom & $urandom & $urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule